// File: doc/BRIEF.md
# Free-running timer with compare-driven output pins

This block holds a 16-bit up-counter that moves forward by one on every cycle where a prescale tick input is high. An 8-bit register port reads the counter as two bytes. Reading the high byte stores the low byte in a buffer. A low-byte read in the very next clock cycle returns that stored byte, so the two reads give one consistent 16-bit value even if the counter steps between them.

There are four compare channels, numbered 0 to 3. Each channel has its own 16-bit compare register. A match happens on a tick where the counter's new value equals that register. On a match, the channel updates its output pin as set by a 2-bit action code in a shared control register. The possible actions are hold, toggle, drive low and drive high. Channel 3 can be held off by an external input. When that input is high, channel 3's pin does not react to matches.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the control register reads 0x00, every compare register reads 0xFFFF and all four output pins are 0.
- R2: The counter steps by one on each clock edge where `prescale_tick` is high and holds otherwise. It wraps from 0xFFFF to 0x0000.
- R3: Writes to the counter offsets 0x0E and 0x0F have no effect on the counter value.
- R4: A read at 0x0E returns counter bits 15:8 in the same cycle. A read at 0x0F in the clock cycle right after a 0x0E read returns counter bits 7:0 as they stood during the 0x0E read.
- R5: A read at 0x0F that does not come in the cycle right after a 0x0E read returns the live counter bits 7:0.
- R6: The control register at 0x20 can be written and read back. Bits 7:6 hold the action code of channel 0, bits 5:4 channel 1, bits 3:2 channel 2 and bits 1:0 channel 3.
- R7: The compare register of channel k has its high byte at 0x18+2k and its low byte at 0x19+2k. Both bytes can be written and read back.
- R8: A channel matches only on a tick edge where the counter's new value equals its compare register. The pin change appears in the same cycle as that counter value, and pins do not change on any other edge.
- R9: On a match, action code 01 inverts the pin, 10 drives it to 0 and 11 drives it to 1.
- R10: On a match with action code 00, the pin keeps its previous value.
- R11: While `last_ch_hold` is high, channel 3's pin ignores matches. The other channels still act on their matches.
- R12: `rd_data` is 0x00 when `rd_en` is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register offset |
| rd_en | input | 1 | Read strobe; the data is combinational in the same cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| prescale_tick | input | 1 | Counter advance enable |
| last_ch_hold | input | 1 | Blocks channel 3's pin actions while high |
| cmp_out | output | 4 | Compare output pins, bit k belongs to channel k |

## Verification
The counter is run through a full 65536-tick cycle to show the wrap. A coherent read is timed so that a tick carries from the low byte into the high byte between the two reads. This separates a buffered low byte from a live one, and a read with a gap cycle shows the buffer is used only once. Every channel goes through the action sequence set, hold, toggle, toggle, clear, hold. Before each match the pin is sampled to catch an early change, and after it the whole pin vector is compared, which catches a wrong channel or a wrong bit pair. A match on channels 0 and 3 together, with the hold input high, separates the gated channel from the free one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;

  // Pin value after a match with the given action
  function automatic logic pin_after(input logic cur, input oc_act_e act);
    logic res;
    case (act)
      ACT_TOGGLE: res = ~cur;
      ACT_LOW:    res = 1'b0;
      ACT_HIGH:   res = 1'b1;
      default:    res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               snap_req,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cnt_nxt,
  output logic [CNT_W/2-1:0] snap_lo,
  output logic               snap_vld
);
  localparam int unsigned HALF_W = CNT_W / 2;

  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      snap_lo  <= '0;
      snap_vld <= 1'b0;
    end else begin
      if (tick) cnt <= cnt_nxt;
      snap_vld <= snap_req;
      if (snap_req) snap_lo <= cnt[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_val,
  input  oc_act_e          act,
  input  logic             allow,
  output logic             hit,
  output logic             pin
);
  logic fire;

  assign hit  = tick && (cnt_nxt == cmp_val);
  assign fire = hit && allow;

  always_ff @(posedge clk) begin
    if (!rst_n) pin <= 1'b0;
    else if (fire) pin <= pin_after(pin, act);
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned N_CH    = 4,
  parameter int unsigned OFF_CHI = 'h0E,
  parameter int unsigned OFF_CLO = 'h0F,
  parameter int unsigned OFF_CMP = 'h18,
  parameter int unsigned OFF_CTL = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              prescale_tick,
  input  logic              last_ch_hold,
  output logic [N_CH-1:0]   cmp_out
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam int unsigned CTL_W = 2 * N_CH;
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(OFF_CHI);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(OFF_CLO);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [DATA_W-1:0] snap_lo;
  logic              snap_vld, snap_req;
  logic [CTL_W-1:0]  ctl_q;
  logic [CNT_W-1:0]  cmp_q [N_CH];
  logic [N_CH-1:0]   oc_hit, sel_hi, sel_lo;

  assign snap_req = rd_en && (addr == A_CHI);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(prescale_tick), .snap_req(snap_req),
    .cnt(cnt_q), .cnt_nxt(cnt_nxt), .snap_lo(snap_lo), .snap_vld(snap_vld)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int unsigned HI_BIT = CTL_W - 1 - 2 * k;
    oc_act_e act_k;
    logic    allow_k;

    assign sel_hi[k] = (addr == ADDR_W'(OFF_CMP + 2 * k));
    assign sel_lo[k] = (addr == ADDR_W'(OFF_CMP + 2 * k + 1));
    assign act_k     = oc_act_e'(ctl_q[HI_BIT -: 2]);
    if (k == N_CH - 1) begin : g_gated
      assign allow_k = !last_ch_hold;
    end else begin : g_free
      assign allow_k = 1'b1;
    end

    tmr_oc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(prescale_tick), .cnt_nxt(cnt_nxt),
      .cmp_val(cmp_q[k]), .act(act_k), .allow(allow_k),
      .hit(oc_hit[k]), .pin(cmp_out[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) cmp_q[k] <= '1;
      else if (wr_en && sel_hi[k]) cmp_q[k][CNT_W-1:DATA_W] <= wr_data;
      else if (wr_en && sel_lo[k]) cmp_q[k][DATA_W-1:0] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en && addr == A_CTL) ctl_q <= wr_data[CTL_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == A_CHI) rd_data = cnt_q[CNT_W-1:DATA_W];
      else if (addr == A_CLO) rd_data = snap_vld ? snap_lo : cnt_q[DATA_W-1:0];
      else if (addr == A_CTL) rd_data = DATA_W'(ctl_q);
      for (int k = 0; k < N_CH; k++) begin
        if (sel_hi[k]) rd_data = cmp_q[k][CNT_W-1:DATA_W];
        if (sel_lo[k]) rd_data = cmp_q[k][DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned A_HI   = 'h0E,
  parameter int unsigned A_LO   = 'h0F
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rd_data,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*N_CH-1:0]   ctl,
  input logic [N_CH-1:0]     hit,
  input logic [N_CH-1:0]     pins,
  input logic                gate
);
  localparam int unsigned CW = 2 * DATA_W;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CW'($past(cnt) + CW'(1)));
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(A_LO) && $past(rd_en && addr == ADDR_W'(A_HI)))
      |-> rd_data == $past(cnt[DATA_W-1:0]));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> $stable(pins));
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> $stable(pins[N_CH-1]));

  for (genvar k = 0; k < N_CH; k++) begin : g_ck
    logic [1:0] code;
    logic       ok;
    assign code = ctl[2*N_CH-1-2*k -: 2];
    assign ok   = (k != N_CH - 1) || !gate;
    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[k] && code == 2'b00) |=> $stable(pins[k]));
    p_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[k] && ok && code == 2'b10) |=> !pins[k]);
    p_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[k] && ok && code == 2'b11) |=> pins[k]);
  end
endmodule

bind oc_timer oc_timer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CH(N_CH), .A_HI(OFF_CHI), .A_LO(OFF_CLO)
) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(prescale_tick), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .cnt(cnt_q), .ctl(ctl_q), .hit(oc_hit), .pins(cmp_out),
  .gate(last_ch_hold)
);

// File: tb/test_oc_timer.sv
module test_oc_timer;
  localparam int CLK_P = 10;
  localparam logic [5:0] A_HI = 6'h0E, A_LO = 6'h0F, A_CTL = 6'h20, A_CMP = 6'h18;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, prescale_tick = 1'b0, last_ch_hold = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic [3:0] cmp_out;

  int tests = 0, fails = 0;
  logic [15:0] exp_cnt = '0;
  logic [3:0]  pin_m = '0;

  always #(CLK_P/2) clk = ~clk;

  oc_timer i_oc_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .prescale_tick(prescale_tick),
    .last_ch_hold(last_ch_hold), .cmp_out(cmp_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle; q is rd_data inside the cycle
  task automatic cyc(input logic r, input logic w, input logic [5:0] a,
                     input logic [7:0] d, input logic t, output logic [7:0] q);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wr_data = d; prescale_tick = t;
    #1 q = rd_data;
    @(posedge clk);
    #1;
    if (t) exp_cnt = exp_cnt + 16'd1;
    rd_en = 1'b0; wr_en = 1'b0; prescale_tick = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] q;
    cyc(1'b0, 1'b1, a, d, 1'b0, q);
  endtask

  task automatic idle(input logic t);
    logic [7:0] q;
    cyc(1'b0, 1'b0, 6'h00, 8'h00, t, q);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] q);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, q);
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(A_HI, h);
    rd(A_LO, l);
    v = {h, l};
  endtask

  function automatic logic model_pin(input logic p, input logic [1:0] c);
    return c[1] ? c[0] : (p ^ c[0]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  q, h;
    logic [1:0]  seq [6];
    seq = '{2'b11, 2'b00, 2'b01, 2'b01, 2'b10, 2'b00};

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 pins", 32'(cmp_out), 32'h0);
    rd_cnt(v); chk("R1 counter", 32'(v), 32'h0);
    rd(A_CTL, q); chk("R1 control", 32'(q), 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(A_CMP + 6'(2*k), h); rd(A_CMP + 6'(2*k+1), q);
      chk("R1 compare", 32'({h, q}), 32'hFFFF);
    end

    // R12 unmapped and idle reads
    rd(6'h05, q); chk("R12 unmapped", 32'(q), 32'h0);
    @(negedge clk); addr = A_HI; #1 chk("R12 no strobe", 32'(rd_data), 32'h0);

    // R2 counting, hold and wrap
    repeat (37) idle(1'b1);
    repeat (5) idle(1'b0);
    rd_cnt(v); chk("R2 count", 32'(v), 32'(exp_cnt));
    while (exp_cnt != 16'hFFFF) idle(1'b1);
    rd_cnt(v); chk("R2 top", 32'(v), 32'hFFFF);
    idle(1'b1);
    rd_cnt(v); chk("R2 wrap", 32'(v), 32'h0000);

    // R3 writes to counter ignored
    repeat (20) idle(1'b1);
    wr(A_HI, 8'hA5); wr(A_LO, 8'h5A);
    rd_cnt(v); chk("R3 write ignored", 32'(v), 32'(exp_cnt));

    // R4 coherent read across a carry
    while (exp_cnt[7:0] != 8'hFF) idle(1'b1);
    v = exp_cnt;
    cyc(1'b1, 1'b0, A_HI, 8'h00, 1'b1, h);
    cyc(1'b1, 1'b0, A_LO, 8'h00, 1'b1, q);
    chk("R4 coherent", 32'({h, q}), 32'(v));
    // R5 gap cycle gives live low byte
    rd(A_HI, h); idle(1'b1);
    rd(A_LO, q); chk("R5 live low", 32'(q), 32'(exp_cnt[7:0]));
    rd(A_LO, q); chk("R5 repeat low", 32'(q), 32'(exp_cnt[7:0]));

    // R6 / R7 readback
    wr(A_CTL, 8'hC6); rd(A_CTL, q); chk("R6 control rw", 32'(q), 32'hC6);
    for (int k = 0; k < 4; k++) begin
      wr(A_CMP + 6'(2*k), 8'(8'h10 + k)); wr(A_CMP + 6'(2*k+1), 8'(8'h80 + k));
      rd(A_CMP + 6'(2*k), h); rd(A_CMP + 6'(2*k+1), q);
      chk("R7 compare rw", 32'({h, q}), 32'({8'(8'h10 + k), 8'(8'h80 + k)}));
    end

    // R8/R9/R10 per channel action sequence
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 6; s++) begin
        wr(A_CTL, 8'(seq[s]) << (6 - 2*k));
        v = exp_cnt + 16'd3;
        wr(A_CMP + 6'(2*k), v[15:8]); wr(A_CMP + 6'(2*k+1), v[7:0]);
        idle(1'b1); idle(1'b1);
        chk("R8 no early change", 32'(cmp_out), 32'(pin_m));
        idle(1'b1);
        pin_m[k] = model_pin(pin_m[k], seq[s]);
        chk(seq[s] == 2'b00 ? "R10 keep" : "R9 action", 32'(cmp_out), 32'(pin_m));
        idle(1'b1);
        chk("R8 no repeat", 32'(cmp_out), 32'(pin_m));
      end
    end

    // R11 gated channel 3, channel 0 free
    wr(A_CTL, 8'b01_00_00_01);
    v = exp_cnt + 16'd2;
    wr(A_CMP, v[15:8]); wr(A_CMP + 6'd1, v[7:0]);
    wr(A_CMP + 6'd6, v[15:8]); wr(A_CMP + 6'd7, v[7:0]);
    last_ch_hold = 1'b1;
    idle(1'b1); idle(1'b1);
    pin_m[0] = ~pin_m[0];
    chk("R11 gated", 32'(cmp_out), 32'(pin_m));
    last_ch_hold = 1'b0;
    v = exp_cnt + 16'd1;
    wr(A_CMP + 6'd6, v[15:8]); wr(A_CMP + 6'd7, v[7:0]);
    idle(1'b1);
    pin_m[3] = ~pin_m[3];
    chk("R11 released", 32'(cmp_out), 32'(pin_m));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule